// File: doc/BRIEF.md
# Quarter-Rate Transmit Serializer

This block turns a stream of 40-bit parallel words into a serial bit stream, one bit per unit interval. It does this in three steps: a 40:8 stage, an 8:4 stage, and a final 4:1 conversion. The 4:1 conversion is not one four-way multiplexer. A 4:2 interleave first steers the four bits of each group onto two lanes: lane 0 carries group bits 0 and 2, and lane 1 carries bits 1 and 3. The quarter-rate phase decides which bit each lane holds. A 2:1 stage running at twice the quarter rate then alternates between the two lanes.

Every stage is modelled on one fast clock whose period is one bit slot. Enable strobes derived from a single slot counter mark the coarser rates. The block raises a one-slot take strobe once per 40 slots. The word on the input in that slot is the next word to be sent. Each lane is loaded one slot before the 2:1 stage selects it, so its value is settled when it is used.

Top module: `tx_quad_serializer`

## Requirements
- R1: While reset is high, and after it is released until the first word's bits arrive, `serial_out` is 0 and `word_take` is 0. The first take occurs in slot 39, counting the first slot after reset release as slot 0.
- R2: `word_take` is high for exactly one slot in every 40 slots, always on the last slot of a quarter-rate period (phase 3).
- R3: `word_in` is sampled only in a slot where `word_take` is high. Its value in any other slot has no effect on `serial_out`.
- R4: Each word is sent LSB first: bit 0, then bit 1, up to bit 39. Consecutive words follow one another with no idle slots.
- R5: If `word_take` is high in slot t, bit j of that word drives `serial_out` in slot t+15+j.
- R6: Lane 0 carries group bits 0 and 2, and lane 1 carries bits 1 and 3. A lane changes only at the slot boundary that comes just before the 2:1 stage selects it, and it holds while it is selected.
- R7: The 2:1 stage alternates lanes every slot, taking lane 0 in the first slot of each group. This yields the order bit 0, 1, 2, 3 within every 4-bit group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-slot clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | WORD_W (40) | Parallel word, sampled in the take slot |
| word_take | output | 1 | High in the slot in which `word_in` is captured |
| serial_out | output | 1 | Serial data, one bit per slot |

## Verification
The bench gives each slot an index counted from reset release. When it sees `word_take` high in slot t, it records that bit j is due in slot t+15+j. This follows from the register chain: word capture, eight slots to the first 8-bit chunk, four to the first group, then one slot each for the lane and the output register. Every slot, the bench checks `serial_out` against that schedule, with 0 as the expected value where no bit is scheduled. It also checks that `word_take` is high exactly when the slot index is 39 modulo 40. Outputs are sampled on the falling edge, and garbage is driven on `word_in` in every slot that is not a take slot.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

    // Width of the group handled by the 4:2 / 2:1 pair; fixed by its structure.
    parameter int GRP_W = 4;

    // Strobes and phase produced by the slot timer for one bit slot.
    typedef struct packed {
        logic [1:0] phase;   // position within the current 4-bit group
        logic       take;    // last slot of a word period
        logic       mid_ld;  // last slot of an 8-bit chunk period
        logic       grp_ld;  // last slot of a 4-bit group period
    } slot_strb_t;

    // Bit of a group that a lane should hold: I phase (phase[1]) picks
    // the low or high pair, lane picks the even or odd member.
    function automatic logic lane_pick(input logic [GRP_W-1:0] grp,
                                       input logic             iq,
                                       input logic             lane);
        return grp[{iq, lane}];
    endfunction

endpackage

// File: rtl/tx_slot_timer.sv
module tx_slot_timer
    import tx_ser_pkg::*;
#(
    parameter int WORD_W = 40,
    parameter int MID_W  = 8
) (
    input  logic       clk,
    input  logic       rst,
    output slot_strb_t strb
);
    localparam int CW = $clog2(WORD_W);
    localparam int MB = $clog2(MID_W);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                          cnt <= '0;
        else if (cnt == CW'(WORD_W - 1))  cnt <= '0;
        else                              cnt <= cnt + 1'b1;
    end

    always_comb begin
        strb.phase  = cnt[1:0];
        strb.take   = (cnt == CW'(WORD_W - 1));
        strb.mid_ld = &cnt[MB-1:0];
        strb.grp_ld = &cnt[1:0];
    end

endmodule

// File: rtl/tx_ratio_stage.sv
module tx_ratio_stage #(
    parameter int IN_W  = 40,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [IN_W-1:0]  in_word,
    output logic [OUT_W-1:0] out_word
);
    localparam int N  = IN_W / OUT_W;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            out_word <= '0;
        end else if (ld) begin
            out_word <= in_word[idx*OUT_W +: OUT_W];
            if (idx == IW'(N - 1)) idx <= '0;
            else                   idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/tx_lane_pair.sv
module tx_lane_pair
    import tx_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       phase,
    input  logic [GRP_W-1:0] grp,
    output logic             lane0,
    output logic             lane1
);
    // Lane 0 loads in even phases, lane 1 in odd phases: each is written
    // one slot before the 2:1 stage reads it.
    always_ff @(posedge clk) begin
        if (rst) begin
            lane0 <= 1'b0;
            lane1 <= 1'b0;
        end else if (phase[0] == 1'b0) begin
            lane0 <= lane_pick(grp, phase[1], 1'b0);
        end else begin
            lane1 <= lane_pick(grp, phase[1], 1'b1);
        end
    end

endmodule

// File: rtl/tx_half_mux.sv
module tx_half_mux (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] phase,
    input  logic       lane0,
    input  logic       lane1,
    output logic       dout
);
    always_ff @(posedge clk) begin
        if (rst)           dout <= 1'b0;
        else if (phase[0]) dout <= lane0;
        else               dout <= lane1;
    end

endmodule

// File: rtl/tx_quad_serializer.sv
module tx_quad_serializer
    import tx_ser_pkg::*;
#(
    parameter int WORD_W = 40,
    parameter int MID_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    output logic              word_take,
    output logic              serial_out
);
    slot_strb_t        strb;
    logic [1:0]        phase;
    logic              mid_ld;
    logic              grp_ld;
    logic [WORD_W-1:0] word_q;
    logic [MID_W-1:0]  mid_q;
    logic [GRP_W-1:0]  grp_q;
    logic              lane0;
    logic              lane1;

    tx_slot_timer #(.WORD_W(WORD_W), .MID_W(MID_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .strb (strb)
    );

    assign phase     = strb.phase;
    assign mid_ld    = strb.mid_ld;
    assign grp_ld    = strb.grp_ld;
    assign word_take = strb.take;

    always_ff @(posedge clk) begin
        if (rst)            word_q <= '0;
        else if (strb.take) word_q <= word_in;
    end

    tx_ratio_stage #(.IN_W(WORD_W), .OUT_W(MID_W)) u_word_to_mid (
        .clk      (clk),
        .rst      (rst),
        .ld       (mid_ld),
        .in_word  (word_q),
        .out_word (mid_q)
    );

    tx_ratio_stage #(.IN_W(MID_W), .OUT_W(GRP_W)) u_mid_to_grp (
        .clk      (clk),
        .rst      (rst),
        .ld       (grp_ld),
        .in_word  (mid_q),
        .out_word (grp_q)
    );

    tx_lane_pair u_lanes (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .grp   (grp_q),
        .lane0 (lane0),
        .lane1 (lane1)
    );

    tx_half_mux u_out (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .lane0 (lane0),
        .lane1 (lane1),
        .dout  (serial_out)
    );

endmodule

// File: rtl/tx_quad_serializer_chk.sv
module tx_quad_serializer_chk #(
    parameter int WORD_W = 40
) (
    input logic       clk,
    input logic       rst,
    input logic       word_take,
    input logic       serial_out,
    input logic [1:0] phase,
    input logic       mid_ld,
    input logic       lane0,
    input logic       lane1
);
    localparam int CW = $clog2(WORD_W);

    logic [CW-1:0] since_take;
    logic          seen_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_take <= '0;
            seen_take  <= 1'b0;
        end else if (word_take) begin
            since_take <= '0;
            seen_take  <= 1'b1;
        end else begin
            since_take <= since_take + 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (word_take == 1'b0 && serial_out == 1'b0));

    a_r2_take_period: assert property (@(posedge clk) disable iff (rst)
        seen_take |-> (word_take == (since_take == CW'(WORD_W - 1))));

    a_r2_take_aligned: assert property (@(posedge clk) disable iff (rst)
        word_take |-> (phase == 2'b11 && mid_ld));

    a_r6_lane0_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(lane0) |-> ($past(phase[0]) == 1'b0));

    a_r6_lane1_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(lane1) |-> ($past(phase[0]) == 1'b1));

endmodule

bind tx_quad_serializer tx_quad_serializer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_take  (word_take),
    .serial_out (serial_out),
    .phase      (phase),
    .mid_ld     (mid_ld),
    .lane0      (lane0),
    .lane1      (lane1)
);

// File: tb/test_tx_quad_serializer.sv
`timescale 1ns/1ps
module test_tx_quad_serializer;
    localparam int WORD_W = 40;
    localparam int LAT    = 15;
    localparam int NWORDS = 12;
    localparam int NSLOTS = WORD_W * NWORDS + 60;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WORD_W-1:0] word_in = '0;
    logic              word_take;
    logic              serial_out;

    int  n;
    int  checks = 0;
    int  errors = 0;
    int  words  = 0;
    bit  done   = 1'b0;
    bit  exp_q [int];

    always #2.5 clk = ~clk;

    tx_quad_serializer #(.WORD_W(WORD_W), .MID_W(8)) i_tx_quad_serializer (
        .clk        (clk),
        .rst        (rst),
        .word_in    (word_in),
        .word_take  (word_take),
        .serial_out (serial_out)
    );

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s slot=%0d actual=%0d expected=%0d", tag, n, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] pattern(input int k);
        logic [63:0] r;
        case (k)
            0: return '0;
            1: return '1;
            2: return {(WORD_W/2){2'b01}};
            3: return {(WORD_W/2){2'b10}};
            4: return WORD_W'(1);
            5: return {1'b1, {(WORD_W-1){1'b0}}};
            6: return {(WORD_W/4){4'b0011}};
            default: begin
                r = {$urandom, $urandom};
                return r[WORD_W-1:0];
            end
        endcase
    endfunction

    initial begin
        logic [63:0]       junk;
        logic [WORD_W-1:0] w;
        bit                e;
        repeat (4) begin
            @(negedge clk);
            check(word_take == 1'b0, "R1 take low in reset", word_take, 0);
            check(serial_out == 1'b0, "R1 output low in reset", serial_out, 0);
        end
        rst = 1'b0;
        for (int s = 0; s < NSLOTS; s++) begin
            e = exp_q.exists(n) ? exp_q[n] : 1'b0;
            if (exp_q.exists(n))
                check(serial_out == e, "R3 R4 R5 R6 R7 serial bit", serial_out, e);
            else
                check(serial_out == 1'b0, "R1 idle output", serial_out, 0);
            check(word_take == ((n % WORD_W) == WORD_W - 1), "R1 R2 take slot",
                  word_take, int'((n % WORD_W) == WORD_W - 1));
            if (word_take) begin
                w = pattern(words);
                for (int j = 0; j < WORD_W; j++) exp_q[n + LAT + j] = w[j];
                words++;
                word_in = w;
            end else begin
                junk = {$urandom, $urandom};
                word_in = junk[WORD_W-1:0];
            end
            @(negedge clk);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20000 * 5.0);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired slot=%0d actual=0 expected=1", n);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule